// File: doc/BRIEF.md
# Peripheral Reset and Clock-Stop Control Registers

This unit keeps the reset state and the clock-stop state of up to 64 peripherals in flip-flops and drives them out as level signals. Software reaches it over a simple register bus that has an address, write data, a write strobe and a combinational read-data return. Each group of 64 lines is split into 32-bit banks. A bank is never written as a whole word. A write to the bank's base address sets the bits written as one. A write to the alias four bytes above clears the bits written as one. Because of this, several agents can change different lines without a read-modify-write sequence.

Each clock line has a stop bit, and the unit also drives the enable that results from it. For every line the enable is the inverted stop bit, except for one line (line 14 by default), which has the opposite polarity: setting its bit turns its clock on. Out of reset, every peripheral is held in reset and every clock is off. For the inverted line, "off" means its bit is clear.

The unit is purely register-based, and the bus access path has no sequencing. The house state-machine style does not fit this block and is not used. Naming, reset and layout follow the house conventions.

Top module: `csr_clkrst_bank`

## Requirements
- R1: Reset banks decode at byte offsets 0x040 (lines 0 to 31) and 0x050 (lines 32 to 63). Clock-stop banks decode at 0x080 (lines 0 to 31) and 0x090 (lines 32 to 63). Line n lives in bank n/32 at bit n%32.
- R2: A strobed write to a bank's base offset sets every bit whose write-data bit is one and leaves the other bits unchanged. The new value appears on the outputs one clock after the write edge.
- R3: A strobed write to base+0x4 clears every bit whose write-data bit is one and leaves the other bits unchanged.
- R4: A read at either the base offset or base+0x4 of a bank returns that bank's live value on `bus_rdata` in the same cycle.
- R5: `rst_line[n]` equals reset bit n, and a one holds peripheral n in reset. `clk_stop[n]` equals clock-stop bit n.
- R6: `clk_en[n]` is the inverse of stop bit n for every line except line 14, where `clk_en[14]` equals stop bit 14.
- R7: After hardware reset, all 64 reset lines are one, all clock-stop bits are one except bit 14, which is zero, and every `clk_en` is zero.
- R8: Any offset outside the eight mapped words reads as zero, and a write to it changes no output.
- R9: With `bus_we` low, no register changes, whatever the address and write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data; ones select the bits to set or clear |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Combinational read data |
| rst_line | output | 64 | Per-peripheral reset, one means held in reset |
| clk_stop | output | 64 | Raw clock-stop register bits |
| clk_en | output | 64 | Effective clock enable after polarity correction |

## Verification
The properties assume that `bus_addr` and `bus_wdata` are stable while `bus_we` is high, and that a write lasts exactly one clock. The stable-hold property also assumes that nothing except a strobed bus write can change a bank. The stimulus drives every bus input on the falling edge and drops the strobe after one cycle, so each write is sampled at exactly one rising edge. Read data is sampled just after the falling edge, with the strobe low, so that a read and a write never overlap in the same cycle.

// File: rtl/csr_clkrst_pkg.sv
`timescale 1ns/1ps
package csr_clkrst_pkg;

    // Kind of access a bus address selects inside a bank
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_SET  = 2'd1,
        ACC_CLR  = 2'd2
    } acc_kind_e;

    // Byte distance from the set alias to the clear alias
    localparam int CLR_ALIAS_OFS = 4;

endpackage

// File: rtl/csr_addr_decode.sv
`timescale 1ns/1ps
module csr_addr_decode
    import csr_clkrst_pkg::*;
#(
    parameter int AW       = 12,
    parameter int NB       = 2,
    parameter int RST_BASE = 'h040,
    parameter int CLK_BASE = 'h080,
    parameter int STRIDE   = 'h010
) (
    input  logic [AW-1:0] addr,
    output logic [NB-1:0] rst_hit,
    output logic [NB-1:0] clk_hit,
    output acc_kind_e     kind
);

    logic [NB-1:0] rst_set_m, rst_clr_m, clk_set_m, clk_clr_m;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        localparam int RS = RST_BASE + b * STRIDE;
        localparam int CS = CLK_BASE + b * STRIDE;
        assign rst_set_m[b] = (addr == AW'(RS));
        assign rst_clr_m[b] = (addr == AW'(RS + CLR_ALIAS_OFS));
        assign clk_set_m[b] = (addr == AW'(CS));
        assign clk_clr_m[b] = (addr == AW'(CS + CLR_ALIAS_OFS));
    end

    assign rst_hit = rst_set_m | rst_clr_m;
    assign clk_hit = clk_set_m | clk_clr_m;

    always_comb begin
        if (|(rst_set_m | clk_set_m))
            kind = ACC_SET;
        else if (|(rst_clr_m | clk_clr_m))
            kind = ACC_CLR;
        else
            kind = ACC_NONE;
    end

endmodule

// File: rtl/csr_line_bank.sv
`timescale 1ns/1ps
module csr_line_bank #(
    parameter int            DW        = 32,
    parameter logic [DW-1:0] RESET_VAL = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic          clr_en,
    input  logic [DW-1:0] mask,
    output logic [DW-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= RESET_VAL;
        else if (set_en)
            q <= q | mask;
        else if (clr_en)
            q <= q & ~mask;
    end

endmodule

// File: rtl/csr_enable_polarity.sv
`timescale 1ns/1ps
module csr_enable_polarity #(
    parameter int N        = 64,
    parameter int INV_LINE = 14
) (
    input  logic [N-1:0] stop,
    output logic [N-1:0] en
);

    for (genvar i = 0; i < N; i++) begin : g_line
        if (i == INV_LINE) begin : g_direct
            assign en[i] = stop[i];
        end else begin : g_invert
            assign en[i] = ~stop[i];
        end
    end

endmodule

// File: rtl/csr_clkrst_bank.sv
`timescale 1ns/1ps
module csr_clkrst_bank
    import csr_clkrst_pkg::*;
#(
    parameter int AW       = 12,
    parameter int DW       = 32,
    parameter int LINES    = 64,
    parameter int RST_BASE = 'h040,
    parameter int CLK_BASE = 'h080,
    parameter int STRIDE   = 'h010,
    parameter int INV_LINE = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    input  logic             bus_we,
    output logic [DW-1:0]    bus_rdata,
    output logic [LINES-1:0] rst_line,
    output logic [LINES-1:0] clk_stop,
    output logic [LINES-1:0] clk_en
);

    localparam int            NB  = LINES / DW;
    localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

    logic [NB-1:0] rst_hit, clk_hit;
    acc_kind_e     kind;
    logic          wr_set, wr_clr;

    logic [DW-1:0] rst_q [NB];
    logic [DW-1:0] clk_q [NB];

    csr_addr_decode #(
        .AW(AW), .NB(NB), .RST_BASE(RST_BASE),
        .CLK_BASE(CLK_BASE), .STRIDE(STRIDE)
    ) u_dec (
        .addr    (bus_addr),
        .rst_hit (rst_hit),
        .clk_hit (clk_hit),
        .kind    (kind)
    );

    assign wr_set = bus_we && (kind == ACC_SET);
    assign wr_clr = bus_we && (kind == ACC_CLR);

    for (genvar b = 0; b < NB; b++) begin : g_bank
        localparam logic [DW-1:0] CLK_RV =
            (INV_LINE / DW == b) ? ~(ONE << (INV_LINE % DW)) : {DW{1'b1}};

        csr_line_bank #(.DW(DW), .RESET_VAL({DW{1'b1}})) u_rst (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_en (wr_set && rst_hit[b]),
            .clr_en (wr_clr && rst_hit[b]),
            .mask   (bus_wdata),
            .q      (rst_q[b])
        );

        csr_line_bank #(.DW(DW), .RESET_VAL(CLK_RV)) u_clk (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_en (wr_set && clk_hit[b]),
            .clr_en (wr_clr && clk_hit[b]),
            .mask   (bus_wdata),
            .q      (clk_q[b])
        );

        assign rst_line[b*DW +: DW] = rst_q[b];
        assign clk_stop[b*DW +: DW] = clk_q[b];
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NB; b++) begin
            if (rst_hit[b]) bus_rdata = bus_rdata | rst_q[b];
            if (clk_hit[b]) bus_rdata = bus_rdata | clk_q[b];
        end
    end

    csr_enable_polarity #(.N(LINES), .INV_LINE(INV_LINE)) u_pol (
        .stop (clk_stop),
        .en   (clk_en)
    );

endmodule

// File: rtl/csr_clkrst_bank_chk.sv
`timescale 1ns/1ps
module csr_clkrst_bank_chk #(
    parameter int AW       = 12,
    parameter int DW       = 32,
    parameter int LINES    = 64,
    parameter int RST_BASE = 'h040,
    parameter int CLK_BASE = 'h080,
    parameter int STRIDE   = 'h010,
    parameter int INV_LINE = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic [AW-1:0]    bus_addr,
    input logic [DW-1:0]    bus_wdata,
    input logic             bus_we,
    input logic [DW-1:0]    bus_rdata,
    input logic [LINES-1:0] rst_line,
    input logic [LINES-1:0] clk_stop,
    input logic [LINES-1:0] clk_en
);

    localparam logic [AW-1:0] RST0 = AW'(RST_BASE);
    localparam logic [AW-1:0] CLK0 = AW'(CLK_BASE);
    localparam logic [AW-1:0] CLK1 = AW'(CLK_BASE + STRIDE);

    // R2
    set_low_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == RST0) |=>
        ((rst_line[DW-1:0] & $past(bus_wdata)) == $past(bus_wdata)));

    // R2
    set_keeps_others_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == RST0) |=>
        ((rst_line[DW-1:0] & ~$past(bus_wdata)) ==
         ($past(rst_line[DW-1:0]) & ~$past(bus_wdata))));

    // R3
    clr_high_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == CLK1 + AW'(4)) |=>
        ((clk_stop[LINES-1:DW] & $past(bus_wdata)) == '0));

    // R4
    rd_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == RST0 + AW'(4)) |-> (bus_rdata == rst_line[DW-1:0]));

    // R6
    inv_line_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == CLK0 && bus_wdata[INV_LINE % DW]) |=>
        clk_en[INV_LINE]);

    // R8
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == '0) |-> (bus_rdata == '0));

    // R9
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(rst_line) && $stable(clk_stop)));

endmodule

bind csr_clkrst_bank csr_clkrst_bank_chk #(
    .AW(AW), .DW(DW), .LINES(LINES), .RST_BASE(RST_BASE),
    .CLK_BASE(CLK_BASE), .STRIDE(STRIDE), .INV_LINE(INV_LINE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .rst_line  (rst_line),
    .clk_stop  (clk_stop),
    .clk_en    (clk_en)
);

// File: tb/csr_clkrst_bank_bench.sv
`timescale 1ns/1ps
module csr_clkrst_bank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [63:0] rst_line, clk_stop, clk_en;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [63:0] m_rst, m_stop;

    always #4 clk = ~clk;

    csr_clkrst_bank u_csr_clkrst_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .rst_line(rst_line),
        .clk_stop(clk_stop), .clk_en(clk_en)
    );

    function automatic logic [63:0] exp_en(input logic [63:0] s);
        logic [63:0] e = ~s;
        e[14] = s[14];
        return e;
    endfunction

    // Bank base for an offset, or -1 when unmapped; sets is_rst/is_clr
    function automatic int map_bank(input logic [11:0] a, output bit is_rst,
                                    output bit is_clr);
        is_rst = 1'b0;
        is_clr = a[2];
        case (a & 12'hFFB)
            12'h040: begin is_rst = 1'b1; return 0; end
            12'h050: begin is_rst = 1'b1; return 1; end
            12'h080: return 0;
            12'h090: return 1;
            default: return -1;
        endcase
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        bit r, c;
        int b = map_bank(a, r, c);
        if (b < 0) return 32'h0;
        return r ? m_rst[b*32 +: 32] : m_stop[b*32 +: 32];
    endfunction

    task automatic model_wr(input logic [11:0] a, input logic [31:0] d);
        bit r, c;
        int b = map_bank(a, r, c);
        if (b < 0) return;
        if (r) begin
            if (c) m_rst[b*32 +: 32] = m_rst[b*32 +: 32] & ~d;
            else   m_rst[b*32 +: 32] = m_rst[b*32 +: 32] | d;
        end else begin
            if (c) m_stop[b*32 +: 32] = m_stop[b*32 +: 32] & ~d;
            else   m_stop[b*32 +: 32] = m_stop[b*32 +: 32] | d;
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        model_wr(a, d);
    endtask

    task automatic chk_out(input string req);
        #1;
        n_run++;
        if (rst_line !== m_rst || clk_stop !== m_stop || clk_en !== exp_en(m_stop)) begin
            n_fail++;
            $display("FAIL %s outputs rst=%h stop=%h en=%h expected rst=%h stop=%h en=%h",
                     req, rst_line, clk_stop, clk_en, m_rst, m_stop, exp_en(m_stop));
        end
    endtask

    task automatic chk_rd(input logic [11:0] a, input string req);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0; bus_wdata = 32'hDEAD_BEEF;
        #1;
        n_run++;
        if (bus_rdata !== exp_read(a)) begin
            n_fail++;
            $display("FAIL %s read @%h got %h expected %h", req, a, bus_rdata,
                     exp_read(a));
        end
    endtask

    task automatic chk_all_reads(input string req);
        for (int b = 0; b < 2; b++) begin
            chk_rd(12'h040 + 12'(b*16), req);
            chk_rd(12'h044 + 12'(b*16), req);
            chk_rd(12'h080 + 12'(b*16), req);
            chk_rd(12'h084 + 12'(b*16), req);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        m_rst  = '1;
        m_stop = ~(64'h1 << 14);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R7: reset state
        chk_out("R7");
        chk_all_reads("R7");

        // R1 R2 R3 R5 R6: walk every line of both groups
        for (int n = 0; n < 64; n++) begin
            logic [11:0] rb = (n < 32) ? 12'h040 : 12'h050;
            logic [11:0] cb = (n < 32) ? 12'h080 : 12'h090;
            logic [31:0] bit1 = 32'h1 << (n % 32);
            wr(rb + 12'h4, bit1);   chk_out("R3");
            wr(rb, bit1);           chk_out("R2");
            wr(rb + 12'h4, bit1);   chk_out("R5");
            wr(cb + 12'h4, bit1);   chk_out("R6");
            wr(cb, bit1);           chk_out("R1");
        end
        chk_all_reads("R4");

        // R2 R3: multi-bit patterns
        wr(12'h044, 32'hFFFF_FFFF); chk_out("R3");
        wr(12'h040, 32'hA5A5_0F0F); chk_out("R2");
        wr(12'h054, 32'h1234_5678); chk_out("R3");
        wr(12'h090, 32'h8000_0001); chk_out("R2");
        wr(12'h084, 32'h0000_C000); chk_out("R6");
        wr(12'h080, 32'h0000_4000); chk_out("R6");
        chk_all_reads("R4");

        // R8: every unmapped word offset up to 0x0FC
        for (int a = 0; a < 256; a += 4) begin
            logic [11:0] ad = 12'(a);
            bit r, c;
            if (map_bank(ad, r, c) < 0) begin
                wr(ad, 32'hFFFF_FFFF);
                chk_out("R8");
                chk_rd(ad, "R8");
            end
        end
        chk_rd(12'hFF0, "R8");

        // R9: strobe low on mapped addresses
        for (int b = 0; b < 8; b++) begin
            @(negedge clk);
            bus_addr = 12'h040 + 12'((b / 4) * 16 + (b % 2) * 4 + ((b / 2) % 2) * 64);
            bus_wdata = 32'hFFFF_FFFF;
            bus_we = 1'b0;
            @(negedge clk);
            chk_out("R9");
        end

        // R7: reset again mid-run
        @(negedge clk);
        rst_n = 1'b0;
        m_rst = '1;
        m_stop = ~(64'h1 << 14);
        @(negedge clk);
        rst_n = 1'b1;
        chk_out("R7");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule